// File: doc/BRIEF.md
# Random Generator Register Front End

This block sits between a 32-bit register bus and a small random number engine. Software writes a command code to ask for a reseed or a fresh batch of random words. It polls a status word that shows the engine's activity, whether the engine holds a seed, and the selected result width. It then reads up to eight 32-bit result words. Three events can raise an interrupt: results ready, reseed finished and generator lockup. Each event has its own enable bit, and a global enable gates the interrupt line. A pending event is cleared by writing a one to its bit.

The engine behind the front end is a stand-in. A reseed takes a fixed number of cycles and then loads a 32-bit entropy word into a Galois LFSR. A generate request takes a fixed number of cycles and then steps that LFSR once for each result word. A zero LFSR state cannot produce output, so it is reported as a lockup. After a lockup the engine counts as unseeded until it is reseeded.

Top module: `rng_ctrl_regs`

## Requirements
- R1: A write to offset 0x00 with value 1 requests generation and value 2 requests a reseed. Any other value has no effect. Offset 0x00 reads as zero.
- R2: Offset 0x04 bit 31 is high for exactly SEED_CYCLES cycles after an accepted reseed, and bit 30 is high for exactly GEN_CYCLES cycles after an accepted generation. The two bits are never high together.
- R3: Offset 0x04 bit 9 rises when a reseed completes and is cleared by reset and by a lockup. Offset 0x04 bit 3 mirrors the width bit.
- R4: Offset 0x08 bit 3 is the width bit, which is 1 for eight words and 0 for four. It resets to 0, and all other bits of 0x08 read as zero.
- R5: When a reseed completes, the LFSR takes the value of entropy_in. One step is s' = (s>>1) ^ (s[0] ? 32'h80200003 : 0). A completed generation stores step i+1 of the state as word i, for i = 0..7, at offset 0x20+4i. The state then becomes word 7.
- R6: While the width bit is 0, offsets 0x30 to 0x3C read as zero. The stored words are kept and reappear when the width bit is set again.
- R7: A generation request on an unseeded engine first performs a full reseed (bit 31), then the generation (bit 30), with no further command needed.
- R8: A command written while either busy bit is high is ignored.
- R9: Offset 0x14 holds the pending events: bit 0 for results ready, bit 1 for reseed done and bit 4 for lockup. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: Offset 0x10 holds enables in bits 0, 1 and 4, plus a global enable in bit 31. irq is high exactly when bit 31 is set and at least one pending bit has its enable set.
- R11: A generation that finishes with LFSR state zero sets lockup pending and clears the seeded bit. It leaves the result words unchanged and does not set results ready.
- R12: Writes to any other offset are ignored, and reads of any other offset, including unaligned ones, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Byte offset of the combinational read |
| rd_data | output | 32 | Read data for rd_addr |
| entropy_in | input | 32 | Seed word sampled when a reseed completes |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench hits the busy window with a second command. A design that accepted it would restart the timer, stretching bit 30, or would overwrite the result words. It requests generation on an unseeded engine. If the implicit reseed were skipped, the results would come from a stale state or bit 31 would never appear. A zero entropy word forces a lockup. A wrong design would then still raise results ready, overwrite the words or stay seeded. The bench also reads the upper words in four-word mode, writes zero to the pending register and reads undefined and unaligned offsets. These expose leaks of stored words, clear-on-any-write bugs and decode aliasing.

// File: rtl/rng_ctrl_regs.sv
`timescale 1ns/1ps
module rng_ctrl_regs #(
  parameter int          SEED_CYCLES = 6,
  parameter int          GEN_CYCLES  = 4,
  parameter logic [31:0] POLY        = 32'h8020_0003,
  parameter int          AW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic [31:0]   entropy_in,
  output logic          irq
);
  localparam int NWORDS = 8;
  localparam int CMAX   = (SEED_CYCLES > GEN_CYCLES) ? SEED_CYCLES : GEN_CYCLES;
  localparam int CW     = $clog2(CMAX) + 1;
  localparam logic [AW-1:0] A_CMD  = AW'(8'h00);
  localparam logic [AW-1:0] A_STAT = AW'(8'h04);
  localparam logic [AW-1:0] A_MODE = AW'(8'h08);
  localparam logic [AW-1:0] A_IEN  = AW'(8'h10);
  localparam logic [AW-1:0] A_PEND = AW'(8'h14);

  typedef enum logic [1:0] {S_IDLE, S_SEED, S_GEN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          seeded, chain_gen, wide;
  logic [31:0]   lfsr;
  logic [31:0]   words [NWORDS];
  logic [2:0]    pend;
  logic [3:0]    ien;
  logic [31:0]   step [NWORDS+1];

  assign step[0] = lfsr;
  for (genvar i = 1; i <= NWORDS; i++) begin : g_step
    assign step[i] = {1'b0, step[i-1][31:1]} ^ (step[i-1][0] ? POLY : 32'h0);
  end

  wire is_seed   = (st == S_SEED);
  wire is_gen    = (st == S_GEN);
  wire cmd_wr    = wr_en && (wr_addr == A_CMD);
  wire cmd_gen   = cmd_wr && (wr_data == 32'd1);
  wire cmd_seed  = cmd_wr && (wr_data == 32'd2);
  wire seed_done = is_seed && (cnt == '0);
  wire gen_done  = is_gen && (cnt == '0);
  wire lock_evt  = gen_done && (lfsr == 32'h0);
  wire rdy_evt   = gen_done && (lfsr != 32'h0);
  wire [2:0] clr = (wr_en && wr_addr == A_PEND) ? {wr_data[4], wr_data[1], wr_data[0]} : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      seeded    <= 1'b0;
      chain_gen <= 1'b0;
      lfsr      <= '0;
      for (int i = 0; i < NWORDS; i++) words[i] <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cmd_gen && seeded) begin
            st  <= S_GEN;
            cnt <= CW'(GEN_CYCLES - 1);
          end else if (cmd_gen || cmd_seed) begin
            st        <= S_SEED;
            cnt       <= CW'(SEED_CYCLES - 1);
            chain_gen <= cmd_gen;
          end
        end
        S_SEED: begin
          if (cnt == '0) begin
            lfsr      <= entropy_in;
            seeded    <= 1'b1;
            chain_gen <= 1'b0;
            if (chain_gen) begin
              st  <= S_GEN;
              cnt <= CW'(GEN_CYCLES - 1);
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_GEN: begin
          if (cnt == '0) begin
            st <= S_IDLE;
            if (lfsr == 32'h0) begin
              seeded <= 1'b0;
            end else begin
              lfsr <= step[NWORDS];
              for (int i = 0; i < NWORDS; i++) words[i] <= step[i+1];
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      ien  <= '0;
      wide <= 1'b0;
    end else begin
      pend <= (pend & ~clr) | {lock_evt, seed_done, rdy_evt};
      if (wr_en && wr_addr == A_MODE) wide <= wr_data[3];
      if (wr_en && wr_addr == A_IEN)  ien  <= {wr_data[31], wr_data[4], wr_data[1], wr_data[0]};
    end
  end

  assign irq = ien[3] & |(pend & ien[2:0]);

  wire       in_words = (rd_addr[AW-1:5] == (AW-5)'(1)) && (rd_addr[1:0] == 2'b00);
  wire [2:0] widx     = rd_addr[4:2];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_STAT: begin
        rd_data[31] = is_seed;
        rd_data[30] = is_gen;
        rd_data[9]  = seeded;
        rd_data[3]  = wide;
      end
      A_MODE: rd_data[3] = wide;
      A_IEN:  rd_data = {ien[3], 26'b0, ien[2], 2'b0, ien[1], ien[0]};
      A_PEND: rd_data = {27'b0, pend[2], 2'b0, pend[1], pend[0]};
      default: if (in_words && (wide || !widx[2])) rd_data = words[widx];
    endcase
  end
endmodule

module rng_ctrl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       is_seed,
  input logic       is_gen,
  input logic       seeded,
  input logic [2:0] pend,
  input logic       irq
);
  p_busy_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_seed && is_gen));
  p_seeded_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seeded) |-> $past(is_seed));
  p_gen_seeded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_gen) |-> ($past(seeded) || $past(is_seed)));
  p_rdy_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> $past(is_gen));
  p_seeddone_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[1]) |-> $past(is_seed));
  p_lock_unseeds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[2]) |-> !seeded);
  p_irq_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != 3'b000));
endmodule

bind rng_ctrl_regs rng_ctrl_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .is_seed(is_seed), .is_gen(is_gen),
  .seeded(seeded), .pend(pend), .irq(irq)
);

// File: tb/rng_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module rng_ctrl_regs_tb_top;
  localparam int SEEDC = 6;
  localparam int GENC  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] entropy_in = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rng_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .entropy_in(entropy_in), .irq(irq)
  );

  int          ms_left, mg_left;
  bit          m_seeded, m_after, m_wide;
  logic [31:0] m_lfsr, m_en, m_pend;
  logic [31:0] m_w [8];

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_left = 0; mg_left = 0; m_seeded = 0; m_after = 0; m_wide = 0;
      m_lfsr = 0; m_en = 0; m_pend = 0;
      for (int i = 0; i < 8; i++) m_w[i] = 0;
    end else begin
      logic [31:0] clr, ev, s;
      ev  = 0;
      clr = (wr_en && wr_addr == 8'h14) ? (wr_data & 32'h13) : 32'h0;
      if (ms_left > 0) begin
        ms_left--;
        if (ms_left == 0) begin
          m_lfsr = entropy_in; m_seeded = 1; ev |= 32'h2;
          if (m_after) begin m_after = 0; mg_left = GENC; end
        end
      end else if (mg_left > 0) begin
        mg_left--;
        if (mg_left == 0) begin
          if (m_lfsr == 0) begin ev |= 32'h10; m_seeded = 0; end
          else begin
            s = m_lfsr;
            for (int i = 0; i < 8; i++) begin s = nxt(s); m_w[i] = s; end
            m_lfsr = s; ev |= 32'h1;
          end
        end
      end else if (wr_en && wr_addr == 8'h00) begin
        if (wr_data == 1) begin
          if (m_seeded) mg_left = GENC;
          else begin ms_left = SEEDC; m_after = 1; end
        end else if (wr_data == 2) ms_left = SEEDC;
      end
      if (wr_en && wr_addr == 8'h08) m_wide = wr_data[3];
      if (wr_en && wr_addr == 8'h10) m_en = wr_data & 32'h8000_0013;
      m_pend = (m_pend & ~clr) | ev;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] r = 0;
    case (a)
      8'h04: r = {ms_left > 0, mg_left > 0, 20'b0, m_seeded, 5'b0, m_wide, 3'b0};
      8'h08: r = {28'b0, m_wide, 3'b0};
      8'h10: r = m_en;
      8'h14: r = m_pend;
      default:
        if (a >= 8'h20 && a <= 8'h3C && a[1:0] == 0)
          r = (m_wide || a < 8'h30) ? m_w[(a - 8'h20) >> 2] : 32'h0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R1";
      8'h04: return "R2";
      8'h08: return "R4";
      8'h10: return "R10";
      8'h14: return "R9";
      default: return (a >= 8'h20 && a <= 8'h3C && a[1:0] == 0) ? "R5" : "R12";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk({31'b0, irq}, {31'b0, m_en[31] && |(m_pend & m_en & 32'h13)}, "R10 irq");
      chk(rd_data, exp_rd(rd_addr), tag_of(rd_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    rd_addr = a;
    #1 chk(rd_data, exp_rd(a), tag);
  endtask

  task automatic wait_idle;
    while (ms_left > 0 || mg_left > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=running expected=idle");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h04, "R3 reset status");
    chk(rd_data, 32'h0, "R3 reset status literal");
    rd(8'h14, "R9 reset pending");
    rd(8'h20, "R5 reset word");
    // R12 undefined and unaligned offsets
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h0C, "R12 undefined read");
    rd(8'h21, "R12 unaligned read");
    rd(8'h40, "R12 beyond words");
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, "R4 only width bit");
    wr(8'h10, 32'h8000_0013);
    rd(8'h10, "R10 enables");
    // R1 ignored codes
    wr(8'h00, 32'd3);
    wr(8'h00, 32'd0);
    rd(8'h04, "R1 ignored codes");
    rd(8'h00, "R1 cmd reads zero");
    // R2 reseed
    entropy_in = 32'h1234_5678;
    wr(8'h00, 32'd2);
    rd(8'h04, "R2 seeding busy");
    wait_idle();
    rd(8'h04, "R3 seeded set");
    rd(8'h14, "R9 seed done pending");
    chk({31'b0, irq}, 32'd1, "R10 irq on seed done");
    wr(8'h14, 32'h0);
    rd(8'h14, "R9 write zero keeps");
    wr(8'h14, 32'h2);
    rd(8'h14, "R9 w1c");
    chk({31'b0, irq}, 32'd0, "R10 irq cleared");
    // R5 generate, R8 ignore while busy
    wr(8'h00, 32'd1);
    rd(8'h04, "R2 generating busy");
    wr(8'h00, 32'd2);
    wait_idle();
    rd(8'h04, "R8 idle after ignored cmd");
    for (int i = 0; i < 8; i++) rd(8'(8'h20 + 4 * i), "R5 result word");
    // R6 narrow mode
    wr(8'h08, 32'h0);
    for (int i = 4; i < 8; i++) rd(8'(8'h20 + 4 * i), "R6 upper zero");
    rd(8'h24, "R6 lower kept");
    wr(8'h08, 32'h8);
    rd(8'h38, "R6 words return");
    // R10 global gate
    wr(8'h10, 32'h0000_0013);
    chk({31'b0, irq}, 32'd0, "R10 global off");
    wr(8'h14, 32'h13);
    wr(8'h10, 32'h8000_0013);
    // R11 lockup
    entropy_in = 32'h0;
    wr(8'h00, 32'd2);
    wait_idle();
    wr(8'h14, 32'h13);
    wr(8'h00, 32'd1);
    wait_idle();
    rd(8'h14, "R11 lockup pending");
    rd(8'h04, "R11 seeded cleared");
    rd(8'h20, "R11 words kept");
    // R7 implicit reseed
    entropy_in = 32'hCAFE_0001;
    wr(8'h14, 32'h13);
    wr(8'h00, 32'd1);
    rd(8'h04, "R7 seeding first");
    repeat (SEEDC) @(negedge clk);
    rd(8'h04, "R7 generating next");
    wait_idle();
    rd(8'h14, "R7 both events");
    rd(8'h3C, "R7 fresh word");
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule